// File: doc/BRIEF.md
# Downstream Request Ordering and Attribute Unit

This block sits on the downstream path between a packet link and a PCI-X style bus. For each request it accepts, it works out the bus attribute bits: relaxed ordering and no-snoop. It also holds back nonposted requests whose ordering stream still has a request in flight. Requests arrive on a valid/ready handshake. Each request carries a kind, a PassPW bit, a command field, a coherent bit, a 4-bit sequence ID and a tag. The translated request leaves on a registered output one cycle after it is accepted.

Relaxed ordering depends on the request kind:
- A posted write uses its PassPW bit.
- A read uses bit 3 of its command field.
- A response inherits the bit from the upstream request it answers. The upstream requests record their attribute in a tag-indexed table through a separate record port.

No-snoop is the inverse of the coherent bit for memory requests and is zero otherwise.

Nonposted requests (reads and nonmemory requests) with a nonzero sequence ID are limited to one outstanding per ID. A busy vector sets a bit on issue and clears it on the matching completion. A blocked request keeps ready low and raises stall, and the requests behind it wait in order.

Top module: `dsreq_order_unit`

## Requirements
- R1: After synchronous reset, out_valid is 0, no sequence ID is busy and the attribute table holds no valid entry.
- R2: A posted write (kind 0) goes out with relaxed ordering equal to its PassPW bit.
- R3: A read (kind 1) goes out with relaxed ordering equal to bit 3 of its command field.
- R4: A response (kind 2) goes out with relaxed ordering equal to the value recorded for its tag, or 0 when the tag has no valid entry. Accepting a response invalidates that entry.
- R5: Posted writes and reads (the memory kinds) go out with no-snoop equal to the inverse of the coherent bit.
- R6: Nonmemory requests (kind 3) go out with relaxed ordering 0 and no-snoop 0, and responses go out with no-snoop 0.
- R7: A read or nonmemory request with a nonzero sequence ID whose ID is busy is not accepted: in_ready is 0 and stall is 1. The ID becomes free at the clock edge where a completion carrying it is presented, so the held request can be accepted in the next cycle.
- R8: Sequence ID 0, posted writes and responses are never held back, and they never mark an ID busy.
- R9: A request accepted at a clock edge appears on out_* with out_valid 1 for exactly the following cycle, and with its kind, sequence ID and tag unchanged.
- R10: When a record write and a response use the same tag in the same cycle, the response sees the table contents from before the write, and the newly written entry remains valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_kind | input | 2 | 0 posted write, 1 read, 2 response, 3 nonmemory |
| in_passpw | input | 1 | PassPW bit of the request |
| in_cmd | input | 6 | Command field; bit 3 is the response-may-pass-write flag |
| in_coh | input | 1 | Coherent bit |
| in_seq | input | 4 | Sequence ID; 0 means unordered |
| in_tag | input | 5 | Tag; for responses, the tag of the upstream request answered |
| up_valid | input | 1 | Record an upstream request's attribute |
| up_tag | input | 5 | Tag of the recorded upstream request |
| up_ro | input | 1 | Relaxed-ordering bit of the recorded upstream request |
| cpl_valid | input | 1 | A nonposted request completed on the bus |
| cpl_seq | input | 4 | Sequence ID of the completed request |
| stall | output | 1 | A valid request is held by sequence ordering |
| out_valid | output | 1 | Translated request present (one cycle) |
| out_kind | output | 2 | Kind of translated request |
| out_seq | output | 4 | Sequence ID of translated request |
| out_tag | output | 5 | Tag of translated request |
| out_ro | output | 1 | Relaxed-ordering attribute |
| out_ns | output | 1 | No-snoop attribute |

## Verification
The bench sends two reads with the same nonzero ID back to back and holds the second across several cycles. It then presents the completion while the second read is still waiting. A design that cleared the ID too late or too early would accept the second read at the wrong edge, or let two reads with one ID be outstanding at once. A design that gated ID 0 or posted writes would stall them with nothing outstanding. Responses are sent to tags that were never recorded, to tags already consumed, and to a tag being rewritten in the same cycle. A design that read stale validity or let the invalidation win would copy the wrong relaxed-ordering bit. Random traffic on a few colliding IDs is compared every cycle against a behavioural model.

// File: rtl/dsro_pkg.sv
package dsro_pkg;
  typedef enum logic [1:0] {
    KIND_PWR    = 2'd0,
    KIND_RD     = 2'd1,
    KIND_RSP    = 2'd2,
    KIND_NONMEM = 2'd3
  } req_kind_e;

  function automatic logic is_nonposted(input logic [1:0] k);
    return (k == KIND_RD) || (k == KIND_NONMEM);
  endfunction
endpackage

// File: rtl/dsro_seq_tracker.sv
module dsro_seq_tracker #(
  parameter int SEQ_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue_valid,
  input  logic [SEQ_W-1:0]        issue_seq,
  input  logic                    cpl_valid,
  input  logic [SEQ_W-1:0]        cpl_seq,
  output logic [(1<<SEQ_W)-1:0]   busy
);
  localparam int SEQ_N = 1 << SEQ_W;

  logic [SEQ_N-1:0] busy_nxt;

  always_comb begin
    busy_nxt = busy;
    if (cpl_valid) busy_nxt[cpl_seq] = 1'b0;
    if (issue_valid && issue_seq != '0) busy_nxt[issue_seq] = 1'b1;
    busy_nxt[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= busy_nxt;
  end

  AST_NO_DOUBLE_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_seq != '0) |-> !busy[issue_seq]); // R7
  AST_ISSUE_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_seq != '0) |=> busy[$past(issue_seq)]); // R7
  AST_ID_ZERO_FREE: assert property (@(posedge clk) disable iff (rst)
    !busy[0]); // R8
endmodule

// File: rtl/dsro_attr_table.sv
module dsro_attr_table #(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_ro,
  input  logic             use_en,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic             rd_ro
);
  localparam int TAG_N = 1 << TAG_W;

  logic             ro_mem [TAG_N];
  logic [TAG_N-1:0] vld;

  always_ff @(posedge clk) begin
    if (wr_en) ro_mem[wr_tag] <= wr_ro;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (use_en) vld[rd_tag] <= 1'b0;
      if (wr_en)  vld[wr_tag] <= 1'b1;
    end
  end

  assign rd_hit = vld[rd_tag];
  assign rd_ro  = ro_mem[rd_tag];

  AST_WRITE_LEAVES_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld[$past(wr_tag)]); // R10
  AST_USE_CONSUMES: assert property (@(posedge clk) disable iff (rst)
    (use_en && !(wr_en && wr_tag == rd_tag)) |=> !vld[$past(rd_tag)]); // R4
endmodule

// File: rtl/dsro_attr_xlate.sv
module dsro_attr_xlate #(
  parameter int CMD_W      = 6,
  parameter int RO_CMD_BIT = 3
) (
  input  logic [1:0]       kind,
  input  logic             passpw,
  input  logic [CMD_W-1:0] cmd,
  input  logic             coh,
  input  logic             tbl_hit,
  input  logic             tbl_ro,
  output logic             ro,
  output logic             ns
);
  import dsro_pkg::*;

  always_comb begin
    ro = 1'b0;
    ns = 1'b0;
    unique case (kind)
      KIND_PWR: begin ro = passpw;          ns = ~coh; end
      KIND_RD:  begin ro = cmd[RO_CMD_BIT]; ns = ~coh; end
      KIND_RSP: begin ro = tbl_hit & tbl_ro; ns = 1'b0; end
      default:  begin ro = 1'b0;            ns = 1'b0; end
    endcase
  end
endmodule

// File: rtl/dsreq_order_unit.sv
module dsreq_order_unit #(
  parameter int SEQ_W      = 4,
  parameter int TAG_W      = 5,
  parameter int CMD_W      = 6,
  parameter int RO_CMD_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic             in_passpw,
  input  logic [CMD_W-1:0] in_cmd,
  input  logic             in_coh,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             up_valid,
  input  logic [TAG_W-1:0] up_tag,
  input  logic             up_ro,
  input  logic             cpl_valid,
  input  logic [SEQ_W-1:0] cpl_seq,
  output logic             stall,
  output logic             out_valid,
  output logic [1:0]       out_kind,
  output logic [SEQ_W-1:0] out_seq,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_ro,
  output logic             out_ns
);
  import dsro_pkg::*;

  localparam int SEQ_N = 1 << SEQ_W;

  logic [SEQ_N-1:0] busy;
  logic             blocked, accept, np;
  logic             tbl_hit, tbl_ro, ro_c, ns_c;

  assign np       = is_nonposted(in_kind);
  assign blocked  = np && (in_seq != '0) && busy[in_seq];
  assign in_ready = !blocked;
  assign stall    = in_valid && blocked;
  assign accept   = in_valid && !blocked;

  dsro_seq_tracker #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst(rst),
    .issue_valid(accept && np), .issue_seq(in_seq),
    .cpl_valid(cpl_valid), .cpl_seq(cpl_seq),
    .busy(busy)
  );

  dsro_attr_table #(.TAG_W(TAG_W)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(up_valid), .wr_tag(up_tag), .wr_ro(up_ro),
    .use_en(accept && in_kind == KIND_RSP), .rd_tag(in_tag),
    .rd_hit(tbl_hit), .rd_ro(tbl_ro)
  );

  dsro_attr_xlate #(.CMD_W(CMD_W), .RO_CMD_BIT(RO_CMD_BIT)) u_xl (
    .kind(in_kind), .passpw(in_passpw), .cmd(in_cmd), .coh(in_coh),
    .tbl_hit(tbl_hit), .tbl_ro(tbl_ro), .ro(ro_c), .ns(ns_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_seq   <= '0;
      out_tag   <= '0;
      out_ro    <= 1'b0;
      out_ns    <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_kind <= in_kind;
        out_seq  <= in_seq;
        out_tag  <= in_tag;
        out_ro   <= ro_c;
        out_ns   <= ns_c;
      end
    end
  end

  AST_SEQ0_NOT_GATED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_seq == '0) |-> in_ready); // R8
  AST_POSTED_NOT_GATED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_kind == KIND_PWR || in_kind == KIND_RSP)) |-> in_ready); // R8
  AST_OUT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready)); // R9
  AST_NONMEM_ATTR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == KIND_NONMEM) |-> (!out_ro && !out_ns)); // R6
  AST_STALL_MEANS_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    stall |-> (in_valid && !in_ready)); // R7
endmodule

// File: tb/dsreq_order_unit_test.sv
`timescale 1ns/1ps
module dsreq_order_unit_test;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_passpw, in_coh, up_valid, up_ro, cpl_valid;
  logic [1:0] in_kind;
  logic [5:0] in_cmd;
  logic [3:0] in_seq, cpl_seq;
  logic [4:0] in_tag, up_tag;
  logic in_ready, stall, out_valid, out_ro, out_ns;
  logic [1:0] out_kind;
  logic [3:0] out_seq;
  logic [4:0] out_tag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit m_busy [16];
  bit m_tv   [32];
  bit m_tro  [32];

  always #2.5 clk = ~clk;

  dsreq_order_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_passpw(in_passpw), .in_cmd(in_cmd), .in_coh(in_coh),
    .in_seq(in_seq), .in_tag(in_tag), .up_valid(up_valid), .up_tag(up_tag),
    .up_ro(up_ro), .cpl_valid(cpl_valid), .cpl_seq(cpl_seq), .stall(stall),
    .out_valid(out_valid), .out_kind(out_kind), .out_seq(out_seq),
    .out_tag(out_tag), .out_ro(out_ro), .out_ns(out_ns)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; in_kind = 0; in_passpw = 0; in_cmd = 0; in_coh = 0;
    in_seq = 0; in_tag = 0; up_valid = 0; up_tag = 0; up_ro = 0;
    cpl_valid = 0; cpl_seq = 0;
  endtask

  // One clock: inputs already driven just after a falling edge.
  task automatic run_cycle();
    bit np, e_rdy, acc, e_ro, e_ns;
    string ro_req, ns_req, rdy_req;
    logic [1:0] k;
    logic [3:0] s;
    logic [4:0] t;
    k = in_kind; s = in_seq; t = in_tag;
    np = (k == 2'd1) || (k == 2'd3);
    e_rdy = !(np && s != 0 && m_busy[s]);
    rdy_req = (np && s != 0) ? "R7" : "R8";
    #1;
    check(in_ready === e_rdy, rdy_req, "in_ready", int'(in_ready), int'(e_rdy));
    check(stall === (in_valid && !e_rdy), "R7", "stall", int'(stall), int'(in_valid && !e_rdy));
    acc = in_valid && e_rdy;
    case (k)
      2'd0: begin e_ro = in_passpw; e_ns = !in_coh; ro_req = "R2"; ns_req = "R5"; end
      2'd1: begin e_ro = in_cmd[3]; e_ns = !in_coh; ro_req = "R3"; ns_req = "R5"; end
      2'd2: begin e_ro = m_tv[t] ? m_tro[t] : 1'b0; e_ns = 0; ro_req = "R4"; ns_req = "R6"; end
      default: begin e_ro = 0; e_ns = 0; ro_req = "R6"; ns_req = "R6"; end
    endcase
    if (up_valid && k == 2'd2 && up_tag == t) ro_req = "R10";
    @(posedge clk);
    if (acc && k == 2'd2) m_tv[t] = 0;
    if (up_valid) begin m_tv[up_tag] = 1; m_tro[up_tag] = up_ro; end
    if (cpl_valid) m_busy[cpl_seq] = 0;
    if (acc && np && s != 0) m_busy[s] = 1;
    @(negedge clk);
    check(out_valid === acc, "R9", "out_valid", int'(out_valid), int'(acc));
    if (acc) begin
      check(out_kind === k, "R9", "out_kind", int'(out_kind), int'(k));
      check(out_seq === s, "R9", "out_seq", int'(out_seq), int'(s));
      check(out_tag === t, "R9", "out_tag", int'(out_tag), int'(t));
      check(out_ro === e_ro, ro_req, "out_ro", int'(out_ro), int'(e_ro));
      check(out_ns === e_ns, ns_req, "out_ns", int'(out_ns), int'(e_ns));
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [3:0] s, input logic [4:0] t,
                      input logic pw, input logic [5:0] c, input logic coh);
    in_valid = 1; in_kind = k; in_seq = s; in_tag = t;
    in_passpw = pw; in_cmd = c; in_coh = coh;
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    for (int i = 0; i < 16; i++) m_busy[i] = 0;
    for (int i = 0; i < 32; i++) begin m_tv[i] = 0; m_tro[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    // R1: an unrecorded tag reads as invalid after reset
    send(2'd2, 4'd0, 5'd9, 0, 0, 0); run_cycle();
    // R1: all IDs free after reset
    send(2'd1, 4'd7, 5'd1, 0, 6'h08, 1); run_cycle();
    idle_inputs(); cpl_valid = 1; cpl_seq = 4'd7; run_cycle();
    cpl_valid = 0;

    // R7: back-to-back same-ID reads; second holds until completion
    send(2'd1, 4'd5, 5'd2, 0, 6'h08, 0); run_cycle();
    send(2'd1, 4'd5, 5'd3, 0, 6'h00, 1); run_cycle();
    check(stall === 1'b1, "R7", "second read stalled", int'(stall), 1);
    run_cycle(); run_cycle();
    cpl_valid = 1; cpl_seq = 4'd5; run_cycle();
    cpl_valid = 0;
    check(in_ready === 1'b1, "R7", "ready after completion", int'(in_ready), 1);
    run_cycle();
    // R8: ID 0 reads and posted writes pass while ID 5 busy
    send(2'd1, 4'd0, 5'd4, 0, 6'h08, 0); run_cycle();
    send(2'd0, 4'd5, 5'd4, 1, 0, 0); run_cycle();
    send(2'd0, 4'd5, 5'd4, 0, 0, 1); run_cycle();
    send(2'd3, 4'd5, 5'd6, 1, 6'h3f, 0); run_cycle();   // blocked nonmemory
    idle_inputs(); cpl_valid = 1; cpl_seq = 4'd5; run_cycle();
    cpl_valid = 0;
    send(2'd3, 4'd5, 5'd6, 1, 6'h3f, 0); run_cycle();   // R6
    idle_inputs(); cpl_valid = 1; cpl_seq = 4'd5; run_cycle();

    // R4: record then respond; second response to same tag gets 0
    idle_inputs(); up_valid = 1; up_tag = 5'd12; up_ro = 1; run_cycle();
    idle_inputs(); send(2'd2, 4'd0, 5'd12, 0, 0, 1); run_cycle();
    run_cycle();
    // R10: record and response collide on one tag
    idle_inputs(); up_valid = 1; up_tag = 5'd20; up_ro = 0; run_cycle();
    send(2'd2, 4'd0, 5'd20, 0, 0, 0); up_valid = 1; up_tag = 5'd20; up_ro = 1; run_cycle();
    idle_inputs(); send(2'd2, 4'd0, 5'd20, 0, 0, 0); run_cycle();
    check(out_ro === 1'b1, "R10", "entry kept after collision", int'(out_ro), 1);

    // Random traffic on a few colliding IDs
    for (int n = 0; n < 4000; n++) begin
      idle_inputs();
      in_valid  = ($urandom % 4) != 0;
      in_kind   = 2'($urandom % 4);
      in_seq    = 4'($urandom % 4);
      in_tag    = 5'($urandom % 8);
      in_passpw = 1'($urandom % 2);
      in_cmd    = 6'($urandom % 64);
      in_coh    = 1'($urandom % 2);
      up_valid  = ($urandom % 3) == 0;
      up_tag    = 5'($urandom % 8);
      up_ro     = 1'($urandom % 2);
      cpl_seq   = 4'(1 + $urandom % 3);
      cpl_valid = m_busy[cpl_seq] && (($urandom % 3) == 0);
      run_cycle();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule